// File: doc/BRIEF.md
# Oldest-first multi-class issue selector

This block is the select half of an out-of-order issue queue. Instructions whose operands are already available are written into it through a multi-lane insert port. Each one carries a 16-bit sequence number, an operation class and a small tag. Every class has its own store of waiting entries, so that each class can later be steered to its own functional units. On every clock edge the block takes up to `ISSUE_W` of the oldest waiting entries over all classes and drives them on a registered issue port. Each issued slot carries the entry's sequence number, class and tag. Slot 0 always holds the oldest entry of the group.

Entries marked non-speculative do not enter a class store. They wait in a small parking table until the commit side names their sequence number on the release port. From then on they compete for issue like any other entry of their class. A squash strobe with a sequence number removes every younger entry in the same cycle, whether it is waiting, parked or being inserted. Sequence numbers wrap, so all age comparisons use modular arithmetic.

Top module: `oldest_issue_sel`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `iss_valid` is all zero. No entry survives reset.
- R2: Within one class, entries issue strictly in age order. Age is decided by sequence number and not by arrival order.
- R3: Across classes, each issue slot takes the oldest remaining entry. When two class heads carry the same sequence number, the lower class index issues first.
- R4: At most `ISSUE_W` entries issue per edge. Valid slots are packed from slot 0 upward. Each filled slot k>0 holds an entry no older than the entry in slot k-1.
- R5: Every accepted entry issues exactly once, with the sequence number, class and tag it was inserted with, unless a squash removes it first.
- R6: An entry inserted with `ins_nonspec`=1 never issues before `rel_valid` names its exact sequence number. The release becomes effective at that edge, and the entry can issue from the following edge on. A release naming no parked entry has no effect.
- R7: A squash with sequence S removes every entry strictly younger than S at that edge. This covers class stores, parked entries and same-cycle inserts. No such entry appears on the issue port after the squash cycle. Entries of age S or older are kept.
- R8: Age comparison is modular. `a` is older than `b` when `(a-b) mod 2^16` has its top bit set; for example 16'hFFF0 is older than 16'h0005.
- R9: A class store holds `CLS_DEPTH` entries and the parking table holds `HOLD_DEPTH`. Free space is counted before that edge's issues are removed. Lanes are served from lane 0 upward, and an insert that finds no free slot is dropped.
- R10: An entry inserted at edge t can first appear on the issue port after edge t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | INS_W | Insert strobe per lane |
| ins_nonspec | input | INS_W | Per lane: park until released |
| ins_class | input | INS_W x CLS_W | Operation class per lane |
| ins_seq | input | INS_W x 16 | Sequence number per lane |
| ins_tag | input | INS_W x TAG_W | Payload tag per lane |
| rel_valid | input | 1 | Commit release strobe |
| rel_seq | input | 16 | Sequence number being released |
| sq_valid | input | 1 | Squash strobe |
| sq_seq | input | 16 | Squash point; younger entries are removed |
| iss_valid | output | ISSUE_W | Issue slot valid, packed from slot 0 |
| iss_seq | output | ISSUE_W x 16 | Issued sequence number per slot |
| iss_class | output | ISSUE_W x CLS_W | Issued class per slot |
| iss_tag | output | ISSUE_W x TAG_W | Issued tag per slot |

## Verification
Several directed patterns each isolate one ordering rule:
- a single class filled out of age order tells age ranking apart from arrival order;
- heads spread over several classes show whether selection is truly global rather than per class;
- equal sequence numbers in two classes expose the class tie-break;
- a burst straddling 16'hFFFF separates modular from plain comparison.

Parking, release of a wrong number, squash in the middle of a backlog and overfilled stores each show whether entries leave only by the allowed paths. A long random run then mixes four-lane bursts, releases, squashes and wrap-around. Against a cycle-level bench model, this catches lost, duplicated or misordered issues.

// File: rtl/iq_sel_pkg.sv
// Shared definitions for the issue selector: sequence type and modular age test.
// Assumes all live sequence numbers lie within half the sequence space.
package iq_sel_pkg;

    localparam int SEQ_W = 16;

    typedef logic [SEQ_W-1:0] seq_t;

    // True when a is older than b under modular arithmetic.
    function automatic logic seq_before(input seq_t a, input seq_t b);
        seq_t diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction

endpackage

// File: rtl/iq_class_bank.sv
// One class store: DEPTH unordered slots of ready entries.
// Several lanes may write in one cycle; lane 0 gets the lowest free slot.
// Free space is judged on the valid bits before this edge's clears.
// Assumes clr (issue or squash) never targets a slot being written.
module iq_class_bank
    import iq_sel_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int INS_W  = 4,
    parameter int TAG_W  = 6,
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [INS_W-1:0]             wr_en,
    input  seq_t [INS_W-1:0]             wr_seq,
    input  logic [INS_W-1:0][TAG_W-1:0]  wr_tag,
    input  logic [DEPTH-1:0]             clr,
    output logic [DEPTH-1:0]             ent_vld,
    output seq_t [DEPTH-1:0]             ent_seq,
    output logic [DEPTH-1:0][TAG_W-1:0]  ent_tag
);

    logic [INS_W-1:0]              wr_ok;
    logic [INS_W-1:0][SLOT_W-1:0]  wr_slot;

    // Hand each writing lane the lowest slot not taken by an earlier lane.
    always_comb begin
        logic [DEPTH-1:0] busy;
        busy = ent_vld;
        for (int w = 0; w < INS_W; w++) begin
            wr_ok[w]   = 1'b0;
            wr_slot[w] = '0;
            if (wr_en[w]) begin
                for (int d = 0; d < DEPTH; d++) begin
                    if (!busy[d] && !wr_ok[w]) begin
                        wr_ok[w]   = 1'b1;
                        wr_slot[w] = SLOT_W'(d);
                    end
                end
            end
            if (wr_ok[w]) busy[wr_slot[w]] = 1'b1;
        end
    end

    // Occupancy: clear issued or squashed slots, then set freshly written ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
        end else begin
            for (int d = 0; d < DEPTH; d++) begin
                if (clr[d]) ent_vld[d] <= 1'b0;
            end
            for (int w = 0; w < INS_W; w++) begin
                if (wr_ok[w]) ent_vld[wr_slot[w]] <= 1'b1;
            end
        end
    end

    // Payload: capture sequence number and tag into the allocated slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_seq <= '0;
            ent_tag <= '0;
        end else begin
            for (int w = 0; w < INS_W; w++) begin
                if (wr_ok[w]) begin
                    ent_seq[wr_slot[w]] <= wr_seq[w];
                    ent_tag[wr_slot[w]] <= wr_tag[w];
                end
            end
        end
    end

endmodule

// File: rtl/iq_hold_table.sv
// Parking table for non-speculative entries, searched by sequence number.
// An entry becomes issue-eligible (ent_rdy) once a release names its number.
// Write allocation follows the same lane rule as the class stores.
// Assumes clr never targets a slot being written.
module iq_hold_table
    import iq_sel_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int INS_W  = 4,
    parameter int TAG_W  = 6,
    parameter int CLS_W  = 2,
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [INS_W-1:0]             wr_en,
    input  seq_t [INS_W-1:0]             wr_seq,
    input  logic [INS_W-1:0][TAG_W-1:0]  wr_tag,
    input  logic [INS_W-1:0][CLS_W-1:0]  wr_cls,
    input  logic                         rel_valid,
    input  seq_t                         rel_seq,
    input  logic [DEPTH-1:0]             clr,
    output logic [DEPTH-1:0]             ent_rdy,
    output seq_t [DEPTH-1:0]             ent_seq,
    output logic [DEPTH-1:0][TAG_W-1:0]  ent_tag,
    output logic [DEPTH-1:0][CLS_W-1:0]  ent_cls
);

    logic [DEPTH-1:0]              held_vld;
    logic [DEPTH-1:0]              released;
    logic [INS_W-1:0]              wr_ok;
    logic [INS_W-1:0][SLOT_W-1:0]  wr_slot;
    logic [DEPTH-1:0]              rel_hit;

    // Lowest-free-slot allocation per lane, in lane order.
    always_comb begin
        logic [DEPTH-1:0] busy;
        busy = held_vld;
        for (int w = 0; w < INS_W; w++) begin
            wr_ok[w]   = 1'b0;
            wr_slot[w] = '0;
            if (wr_en[w]) begin
                for (int d = 0; d < DEPTH; d++) begin
                    if (!busy[d] && !wr_ok[w]) begin
                        wr_ok[w]   = 1'b1;
                        wr_slot[w] = SLOT_W'(d);
                    end
                end
            end
            if (wr_ok[w]) busy[wr_slot[w]] = 1'b1;
        end
    end

    // Match the release number against parked, not yet released entries.
    always_comb begin
        for (int d = 0; d < DEPTH; d++) begin
            rel_hit[d] = rel_valid && held_vld[d] && !released[d] && (ent_seq[d] == rel_seq);
        end
    end

    assign ent_rdy = held_vld & released;

    // Occupancy and release state; a clear wins over a same-cycle release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_vld <= '0;
            released <= '0;
        end else begin
            for (int d = 0; d < DEPTH; d++) begin
                if (clr[d]) begin
                    held_vld[d] <= 1'b0;
                    released[d] <= 1'b0;
                end else if (rel_hit[d]) begin
                    released[d] <= 1'b1;
                end
            end
            for (int w = 0; w < INS_W; w++) begin
                if (wr_ok[w]) begin
                    held_vld[wr_slot[w]] <= 1'b1;
                    released[wr_slot[w]] <= 1'b0;
                end
            end
        end
    end

    // Payload capture for newly parked entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_seq <= '0;
            ent_tag <= '0;
            ent_cls <= '0;
        end else begin
            for (int w = 0; w < INS_W; w++) begin
                if (wr_ok[w]) begin
                    ent_seq[wr_slot[w]] <= wr_seq[w];
                    ent_tag[wr_slot[w]] <= wr_tag[w];
                    ent_cls[wr_slot[w]] <= wr_cls[w];
                end
            end
        end
    end

endmodule

// File: rtl/iq_age_pick.sv
// Combinational oldest-first selector over a flat candidate pool.
// Each issue slot first reduces every class to its oldest remaining entry
// (its head); the heads are then ordered by age, lower class winning ties.
// The winner is removed from the pool before the next slot is filled, so the
// class whose head issued is re-ranked by its next-younger entry.
// Assumes no two candidates of one class carry equal sequence numbers
// (if they do, the lower pool index wins).
module iq_age_pick
    import iq_sel_pkg::*;
#(
    parameter int NUM_CLS = 4,
    parameter int NCAND   = 20,
    parameter int ISSUE_W = 2,
    parameter int CLS_W   = 2,
    parameter int IDX_W   = 5
) (
    input  logic [NCAND-1:0]               cand_vld,
    input  seq_t [NCAND-1:0]               cand_seq,
    input  logic [NCAND-1:0][CLS_W-1:0]    cand_cls,
    output logic [ISSUE_W-1:0]             pick_vld,
    output logic [ISSUE_W-1:0][IDX_W-1:0]  pick_idx,
    output logic [NCAND-1:0]               pick_mask
);

    // Slot-by-slot selection: class heads first, then age order of the heads.
    always_comb begin
        logic [NCAND-1:0]              taken;
        logic [NUM_CLS-1:0]            head_vld;
        seq_t [NUM_CLS-1:0]            head_seq;
        logic [NUM_CLS-1:0][IDX_W-1:0] head_idx;
        logic                          best_vld;
        seq_t                          best_seq;
        logic [IDX_W-1:0]              best_idx;

        taken = '0;
        for (int s = 0; s < ISSUE_W; s++) begin
            for (int c = 0; c < NUM_CLS; c++) begin
                head_vld[c] = 1'b0;
                head_seq[c] = '0;
                head_idx[c] = '0;
                for (int i = 0; i < NCAND; i++) begin
                    if (cand_vld[i] && !taken[i] && (cand_cls[i] == CLS_W'(c))) begin
                        if (!head_vld[c] || seq_before(cand_seq[i], head_seq[c])) begin
                            head_vld[c] = 1'b1;
                            head_seq[c] = cand_seq[i];
                            head_idx[c] = IDX_W'(i);
                        end
                    end
                end
            end
            best_vld = 1'b0;
            best_seq = '0;
            best_idx = '0;
            for (int c = 0; c < NUM_CLS; c++) begin
                if (head_vld[c] && (!best_vld || seq_before(head_seq[c], best_seq))) begin
                    best_vld = 1'b1;
                    best_seq = head_seq[c];
                    best_idx = head_idx[c];
                end
            end
            pick_vld[s] = best_vld;
            pick_idx[s] = best_idx;
            if (best_vld) taken[best_idx] = 1'b1;
        end
        pick_mask = taken;
    end

endmodule

// File: rtl/oldest_issue_sel.sv
// Oldest-first issue selector across per-class ready stores.
// Inserts land in the class store of their class, or in the parking table
// when non-speculative. Squash removes younger entries at the same edge and
// also blocks them from being picked in that cycle. Up to ISSUE_W picks are
// registered onto the issue port each edge and removed from storage.
// Assumes live sequence numbers span less than half the 16-bit space.
module oldest_issue_sel
    import iq_sel_pkg::*;
#(
    parameter int NUM_CLS    = 4,
    parameter int CLS_DEPTH  = 4,
    parameter int HOLD_DEPTH = 4,
    parameter int ISSUE_W    = 2,
    parameter int INS_W      = 4,
    parameter int TAG_W      = 6,
    localparam int CLS_W     = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [INS_W-1:0]              ins_valid,
    input  logic [INS_W-1:0]              ins_nonspec,
    input  logic [INS_W-1:0][CLS_W-1:0]   ins_class,
    input  logic [INS_W-1:0][SEQ_W-1:0]   ins_seq,
    input  logic [INS_W-1:0][TAG_W-1:0]   ins_tag,
    input  logic                          rel_valid,
    input  logic [SEQ_W-1:0]              rel_seq,
    input  logic                          sq_valid,
    input  logic [SEQ_W-1:0]              sq_seq,
    output logic [ISSUE_W-1:0]            iss_valid,
    output logic [ISSUE_W-1:0][SEQ_W-1:0] iss_seq,
    output logic [ISSUE_W-1:0][CLS_W-1:0] iss_class,
    output logic [ISSUE_W-1:0][TAG_W-1:0] iss_tag
);

    localparam int NBANK = NUM_CLS * CLS_DEPTH;
    localparam int NCAND = NBANK + HOLD_DEPTH;
    localparam int IDX_W = (NCAND > 1) ? $clog2(NCAND) : 1;

    logic [INS_W-1:0]              lane_ok;
    logic [INS_W-1:0]              hold_wr;
    logic [NCAND-1:0]              cand_raw;
    logic [NCAND-1:0]              cand_kill;
    logic [NCAND-1:0]              cand_vld;
    logic [NCAND-1:0]              pick_mask;
    logic [NCAND-1:0]              cand_clr;
    seq_t [NCAND-1:0]              cand_seq;
    logic [NCAND-1:0][TAG_W-1:0]   cand_tag;
    logic [NCAND-1:0][CLS_W-1:0]   cand_cls;
    logic [ISSUE_W-1:0]            pick_vld;
    logic [ISSUE_W-1:0][IDX_W-1:0] pick_idx;

    // Drop inserts that the concurrent squash makes wrong-path.
    always_comb begin
        for (int w = 0; w < INS_W; w++) begin
            lane_ok[w] = ins_valid[w] && !(sq_valid && seq_before(sq_seq, ins_seq[w]));
            hold_wr[w] = lane_ok[w] && ins_nonspec[w];
        end
    end

    // Squash kill mask over the whole pool; killed entries are not pickable.
    always_comb begin
        for (int i = 0; i < NCAND; i++) begin
            cand_kill[i] = sq_valid && seq_before(sq_seq, cand_seq[i]);
        end
        cand_vld = cand_raw & ~cand_kill;
        cand_clr = pick_mask | cand_kill;
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        logic [INS_W-1:0] bank_wr;

        // Steer speculative lanes of this class into its store.
        always_comb begin
            for (int w = 0; w < INS_W; w++) begin
                bank_wr[w] = lane_ok[w] && !ins_nonspec[w] && (ins_class[w] == CLS_W'(c));
            end
        end

        iq_class_bank #(
            .DEPTH (CLS_DEPTH),
            .INS_W (INS_W),
            .TAG_W (TAG_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr),
            .wr_seq  (ins_seq),
            .wr_tag  (ins_tag),
            .clr     (cand_clr[c*CLS_DEPTH +: CLS_DEPTH]),
            .ent_vld (cand_raw[c*CLS_DEPTH +: CLS_DEPTH]),
            .ent_seq (cand_seq[c*CLS_DEPTH +: CLS_DEPTH]),
            .ent_tag (cand_tag[c*CLS_DEPTH +: CLS_DEPTH])
        );

        assign cand_cls[c*CLS_DEPTH +: CLS_DEPTH] = {CLS_DEPTH{CLS_W'(c)}};
    end

    iq_hold_table #(
        .DEPTH (HOLD_DEPTH),
        .INS_W (INS_W),
        .TAG_W (TAG_W),
        .CLS_W (CLS_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (hold_wr),
        .wr_seq    (ins_seq),
        .wr_tag    (ins_tag),
        .wr_cls    (ins_class),
        .rel_valid (rel_valid),
        .rel_seq   (rel_seq),
        .clr       (cand_clr[NBANK +: HOLD_DEPTH]),
        .ent_rdy   (cand_raw[NBANK +: HOLD_DEPTH]),
        .ent_seq   (cand_seq[NBANK +: HOLD_DEPTH]),
        .ent_tag   (cand_tag[NBANK +: HOLD_DEPTH]),
        .ent_cls   (cand_cls[NBANK +: HOLD_DEPTH])
    );

    iq_age_pick #(
        .NUM_CLS (NUM_CLS),
        .NCAND   (NCAND),
        .ISSUE_W (ISSUE_W),
        .CLS_W   (CLS_W),
        .IDX_W   (IDX_W)
    ) u_pick (
        .cand_vld  (cand_vld),
        .cand_seq  (cand_seq),
        .cand_cls  (cand_cls),
        .pick_vld  (pick_vld),
        .pick_idx  (pick_idx),
        .pick_mask (pick_mask)
    );

    // Register the picked group onto the issue port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= '0;
            iss_seq   <= '0;
            iss_class <= '0;
            iss_tag   <= '0;
        end else begin
            for (int s = 0; s < ISSUE_W; s++) begin
                iss_valid[s] <= pick_vld[s];
                iss_seq[s]   <= cand_seq[pick_idx[s]];
                iss_class[s] <= cand_cls[pick_idx[s]];
                iss_tag[s]   <= cand_tag[pick_idx[s]];
            end
        end
    end

endmodule

// File: rtl/iq_sel_checks.sv
// Checker for the issue selector's port-level ordering and squash rules.
// Attached to every instance of oldest_issue_sel through the bind below.
module iq_sel_checks
    import iq_sel_pkg::*;
#(
    parameter int ISSUE_W = 2,
    parameter int CLS_W   = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          sq_valid,
    input logic [SEQ_W-1:0]              sq_seq,
    input logic [ISSUE_W-1:0]            iss_valid,
    input logic [ISSUE_W-1:0][SEQ_W-1:0] iss_seq,
    input logic [ISSUE_W-1:0][CLS_W-1:0] iss_class
);

    // R1: reset leaves the issue port quiet on the following edge.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (iss_valid == '0));

    // R4: valid slots are contiguous from slot 0.
    a_r4_packed: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid & (iss_valid + ISSUE_W'(1))) == '0);

    for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
        if (s > 0) begin : g_ord
            // R4 and R3: a later slot is never older than the slot before it.
            a_r4_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[s] |-> (!seq_before(iss_seq[s], iss_seq[s-1]) &&
                                  ((iss_seq[s] != iss_seq[s-1]) || (iss_class[s] >= iss_class[s-1]))));
        end
        // R7: nothing younger than the squash point issues right after it.
        a_r7_squash_gone: assert property (@(posedge clk) disable iff (!rst_n)
            sq_valid |=> !(iss_valid[s] && seq_before($past(sq_seq), iss_seq[s])));
    end

endmodule

bind oldest_issue_sel iq_sel_checks #(
    .ISSUE_W (ISSUE_W),
    .CLS_W   (CLS_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .sq_valid  (sq_valid),
    .sq_seq    (sq_seq),
    .iss_valid (iss_valid),
    .iss_seq   (iss_seq),
    .iss_class (iss_class)
);

// File: tb/oldest_issue_sel_tb.sv
module oldest_issue_sel_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CLS    = 4;
    localparam int CLS_DEPTH  = 4;
    localparam int HOLD_DEPTH = 4;
    localparam int ISSUE_W    = 2;
    localparam int INS_W      = 4;
    localparam int TAG_W      = 6;
    localparam int CLS_W      = 2;
    localparam int POOL       = NUM_CLS * CLS_DEPTH + HOLD_DEPTH;

    logic                          clk = 1'b0;
    logic                          rst_n = 1'b0;
    logic [INS_W-1:0]              ins_valid = '0;
    logic [INS_W-1:0]              ins_nonspec = '0;
    logic [INS_W-1:0][CLS_W-1:0]   ins_class = '0;
    logic [INS_W-1:0][15:0]        ins_seq = '0;
    logic [INS_W-1:0][TAG_W-1:0]   ins_tag = '0;
    logic                          rel_valid = 1'b0;
    logic [15:0]                   rel_seq = '0;
    logic                          sq_valid = 1'b0;
    logic [15:0]                   sq_seq = '0;
    logic [ISSUE_W-1:0]            iss_valid;
    logic [ISSUE_W-1:0][15:0]      iss_seq;
    logic [ISSUE_W-1:0][CLS_W-1:0] iss_class;
    logic [ISSUE_W-1:0][TAG_W-1:0] iss_tag;

    oldest_issue_sel #(
        .NUM_CLS (NUM_CLS), .CLS_DEPTH (CLS_DEPTH), .HOLD_DEPTH (HOLD_DEPTH),
        .ISSUE_W (ISSUE_W), .INS_W (INS_W), .TAG_W (TAG_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .ins_valid (ins_valid), .ins_nonspec (ins_nonspec), .ins_class (ins_class),
        .ins_seq (ins_seq), .ins_tag (ins_tag),
        .rel_valid (rel_valid), .rel_seq (rel_seq),
        .sq_valid (sq_valid), .sq_seq (sq_seq),
        .iss_valid (iss_valid), .iss_seq (iss_seq), .iss_class (iss_class), .iss_tag (iss_tag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model of the stored entries.
    bit       m_v    [POOL];
    bit       m_ns   [POOL];
    bit       m_held [POOL];
    int       m_cls  [POOL];
    bit [15:0] m_seq [POOL];
    bit [TAG_W-1:0] m_tag [POOL];

    function automatic bit older(bit [15:0] a, bit [15:0] b);
        bit [15:0] d;
        d = a - b;
        return d[15];
    endfunction

    function automatic bit [TAG_W-1:0] tag_of(bit [15:0] s);
        return s[TAG_W-1:0] ^ 6'h15;
    endfunction

    task automatic lane(int w, bit ns, int cls, bit [15:0] s);
        ins_valid[w]   = 1'b1;
        ins_nonspec[w] = ns;
        ins_class[w]   = CLS_W'(cls);
        ins_seq[w]     = s;
        ins_tag[w]     = tag_of(s);
    endtask

    // One clock: predict the issue group, compare after the edge, update the model.
    task automatic tick(string req);
        bit kill [POOL];
        bit taken [POOL];
        bit [ISSUE_W-1:0] ev;
        bit [15:0] es [ISSUE_W];
        int ec [ISSUE_W];
        bit [TAG_W-1:0] et [ISSUE_W];
        int cnt_b [NUM_CLS];
        int cnt_h;
        bit mis;
        for (int i = 0; i < POOL; i++) begin
            kill[i]  = m_v[i] && sq_valid && older(sq_seq, m_seq[i]);
            taken[i] = 1'b0;
        end
        ev = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            int best;
            best = -1;
            for (int i = 0; i < POOL; i++) begin
                if (m_v[i] && !m_held[i] && !kill[i] && !taken[i]) begin
                    if (best < 0 || older(m_seq[i], m_seq[best]) ||
                        (m_seq[i] == m_seq[best] && m_cls[i] < m_cls[best])) best = i;
                end
            end
            es[k] = '0; ec[k] = 0; et[k] = '0;
            if (best >= 0) begin
                taken[best] = 1'b1;
                ev[k] = 1'b1;
                es[k] = m_seq[best]; ec[k] = m_cls[best]; et[k] = m_tag[best];
            end
        end
        for (int c = 0; c < NUM_CLS; c++) cnt_b[c] = 0;
        cnt_h = 0;
        for (int i = 0; i < POOL; i++) begin
            if (m_v[i] && m_ns[i]) cnt_h++;
            else if (m_v[i]) cnt_b[m_cls[i]]++;
        end
        @(posedge clk);
        #1;
        mis = (iss_valid !== ev);
        for (int k = 0; k < ISSUE_W; k++) begin
            if (ev[k] && (iss_seq[k] !== es[k] || iss_class[k] !== CLS_W'(ec[k]) || iss_tag[k] !== et[k]))
                mis = 1'b1;
        end
        checks++;
        if (mis) begin
            failures++;
            $display("FAIL %s valid actual=%b expected=%b", req, iss_valid, ev);
            for (int k = 0; k < ISSUE_W; k++)
                $display("  slot %0d actual seq=%h cls=%0d tag=%h expected seq=%h cls=%0d tag=%h",
                         k, iss_seq[k], iss_class[k], iss_tag[k], es[k], ec[k], et[k]);
        end
        for (int i = 0; i < POOL; i++) if (taken[i] || kill[i]) m_v[i] = 1'b0;
        if (rel_valid) begin
            for (int i = 0; i < POOL; i++)
                if (m_v[i] && m_ns[i] && m_held[i] && m_seq[i] == rel_seq) m_held[i] = 1'b0;
        end
        for (int w = 0; w < INS_W; w++) begin
            if (ins_valid[w] && !(sq_valid && older(sq_seq, ins_seq[w]))) begin
                bit room;
                room = ins_nonspec[w] ? (cnt_h < HOLD_DEPTH) : (cnt_b[ins_class[w]] < CLS_DEPTH);
                if (room) begin
                    bit placed;
                    placed = 1'b0;
                    if (ins_nonspec[w]) cnt_h++; else cnt_b[ins_class[w]]++;
                    for (int i = 0; i < POOL; i++) begin
                        if (!m_v[i] && !placed) begin
                            placed = 1'b1;
                            m_v[i] = 1'b1; m_ns[i] = ins_nonspec[w]; m_held[i] = ins_nonspec[w];
                            m_cls[i] = int'(ins_class[w]); m_seq[i] = ins_seq[w]; m_tag[i] = ins_tag[w];
                        end
                    end
                end
            end
        end
        ins_valid = '0; ins_nonspec = '0;
        rel_valid = 1'b0; sq_valid = 1'b0;
    endtask

    task automatic idle(int n, string req);
        for (int j = 0; j < n; j++) tick(req);
    endtask

    initial begin
        int unsigned seedv;
        bit [15:0] nseq;
        seedv = $urandom(32'h5eed_0427);
        for (int i = 0; i < POOL; i++) m_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (iss_valid !== '0) begin
            failures++;
            $display("FAIL R1 during reset actual=%b expected=0", iss_valid);
        end
        rst_n = 1'b1;
        idle(2, "R1");

        // R10 and R2: one class filled out of age order.
        lane(0, 0, 2, 16'h0030); lane(1, 0, 2, 16'h0020); lane(2, 0, 2, 16'h0028); lane(3, 0, 2, 16'h0024);
        tick("R10");
        idle(3, "R2");

        // R3: heads spread over classes.
        lane(0, 0, 3, 16'h0050); lane(1, 0, 0, 16'h0053); lane(2, 0, 1, 16'h0041); lane(3, 0, 3, 16'h0044);
        idle(4, "R3");

        // R3: equal age in two classes, lower class first.
        lane(0, 0, 3, 16'h0060); lane(1, 0, 1, 16'h0060);
        idle(3, "R3");

        // R8: burst across the wrap point.
        lane(0, 0, 0, 16'h0005); lane(1, 0, 1, 16'hFFF0); lane(2, 0, 0, 16'hFFFA); lane(3, 0, 2, 16'h0002);
        idle(4, "R8");

        // R6: parked entry waits; wrong-number release ignored; real release frees it.
        lane(0, 1, 0, 16'h0100); lane(1, 0, 1, 16'h0101);
        idle(3, "R6");
        rel_valid = 1'b1; rel_seq = 16'h0123;
        idle(3, "R6");
        rel_valid = 1'b1; rel_seq = 16'h0100;
        idle(3, "R6");

        // R7: squash in the middle of a backlog, plus parked and same-cycle victims.
        lane(0, 0, 0, 16'h0200); lane(1, 0, 0, 16'h0201); lane(2, 0, 0, 16'h0203); lane(3, 1, 2, 16'h0204);
        tick("R7");
        sq_valid = 1'b1; sq_seq = 16'h0201;
        lane(0, 0, 1, 16'h0202); lane(1, 0, 1, 16'h01FF);
        tick("R7");
        rel_valid = 1'b1; rel_seq = 16'h0204;
        idle(4, "R7");

        // R9: class store overfill, lane order, then parking overfill.
        lane(0, 0, 0, 16'h0300); lane(1, 0, 0, 16'h0301); lane(2, 0, 0, 16'h0302); lane(3, 0, 0, 16'h0303);
        tick("R9");
        lane(0, 0, 0, 16'h0304); lane(1, 0, 0, 16'h0305);
        idle(4, "R9");
        lane(0, 1, 1, 16'h0310); lane(1, 1, 1, 16'h0311); lane(2, 1, 1, 16'h0312); lane(3, 1, 1, 16'h0313);
        tick("R9");
        lane(0, 1, 1, 16'h0314);
        tick("R9");
        rel_valid = 1'b1; rel_seq = 16'h0314;
        tick("R9");
        for (int q = 0; q < 4; q++) begin
            rel_valid = 1'b1; rel_seq = 16'h0310 + 16'(q);
            tick("R6");
        end
        idle(4, "R5");

        // Random mix: bursts, releases, squashes, wrap-around (R5 overall).
        nseq = 16'hF000;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            for (int w = 0; w < INS_W; w++) begin
                if ($urandom_range(99, 0) < 55) begin
                    lane(w, ($urandom_range(99, 0) < 15), $urandom_range(NUM_CLS-1, 0), nseq);
                    nseq = nseq + 16'd1;
                end
            end
            if ($urandom_range(99, 0) < 35) begin
                int start;
                bit found;
                start = $urandom_range(POOL-1, 0);
                found = 1'b0;
                for (int j = 0; j < POOL; j++) begin
                    int i;
                    i = (start + j) % POOL;
                    if (!found && m_v[i] && m_held[i]) begin
                        found = 1'b1; rel_valid = 1'b1; rel_seq = m_seq[i];
                    end
                end
                if (!found) begin rel_valid = 1'b1; rel_seq = nseq + 16'd9; end
            end
            if ($urandom_range(99, 0) < 3) begin
                sq_valid = 1'b1;
                sq_seq = nseq - 16'd1 - 16'($urandom_range(7, 0));
                nseq = sq_seq + 16'd1;
            end
            tick("R5");
        end
        idle(6, "R5");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule